// File: doc/BRIEF.md
# Pixel Load Resynchronizer and Serializer

This block sits between a slow load strobe and the fast pixel clock. A packed word holds several pixels, each with an 8-bit colour index and a 2-bit overlay code. The word is captured into a first register stage at the clock edge where the strobe is first seen high. The strobe also passes through a two-flop synchronizer and an edge detector, which produce an internal load pulse in the pixel clock domain. That pulse copies the captured word into a second register bank. The bank is then sent out one pixel per clock, in either a four-pixel or a five-pixel rotation.

A cadence tracker predicts where the next strobe edge should land, using a counter modulo the selected ratio. It raises a lock flag once the strobe keeps to that cadence. Any early, late or missing edge clears the flag, and so does a change of the ratio select. The counter then realigns to the next edge it sees. Every detected edge still reloads the bank, so the output stream follows the strobe even while the block is unlocked.

Top module: `pix_load_mux`

## Requirements
- R1: The first-stage register captures `word_i` at the rising clock edge where `strobe_i` is sampled high after having been sampled low at the edge before.
- R2: The second bank is loaded at the second clock edge after that capture edge, which is within 1 to 4 clocks of the strobe rise. Lane 0 appears on the outputs in the cycle that follows.
- R3: Lane k of the word occupies bits [10k+7 : 10k] for the colour and [10k+9 : 10k+8] for the overlay. Lanes are output starting at lane 0, advancing by one lane per clock.
- R4: With `five_i` = 0 the rotation covers lanes 0 to 3. With `five_i` = 1 it covers lanes 0 to 4. With no new load, the lane index wraps back to 0 after the last lane.
- R5: `locked_o` goes to 1 after two consecutive detected strobe edges each arrive exactly N clocks after the previous edge (N = 4 or 5). After only one such edge it stays at 0.
- R6: An edge that arrives early or late, or an expected edge that does not arrive, clears `locked_o`. The tracker realigns to the next edge, so two further on-time edges restore the lock.
- R7: A change of `five_i` clears `locked_o` on the following clock.
- R8: While reset is held, `locked_o`, `pix_o` and `ovl_o` are 0.
- R9: Every detected strobe edge reloads the bank and restarts the rotation at lane 0, whatever the lock state. An early strobe cuts short the previous rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Slow load strobe, asynchronous to clk |
| five_i | input | 1 | Ratio select: 0 gives 4 lanes, 1 gives 5 lanes |
| word_i | input | 50 | Packed pixels, lane k at bits [10k+9 : 10k] |
| pix_o | output | 8 | Colour index of the current lane |
| ovl_o | output | 2 | Overlay code of the current lane |
| locked_o | output | 1 | Strobe cadence matches the selected ratio |

## Verification
The serializer is driven with steady 4:1 and 5:1 strobe trains that carry distinct words. These show whether lane order, field positions and the load lag are right. Trains with a late strobe, a shortened period and a long gap separate three behaviours: the lock being lost, a truncated rotation being restarted, and the lane index wrapping without a load. The lock flag is sampled both after two edges and after three edges. This shows that it waits for two on-time edges, and then that it drops on a missing edge and on a change of the ratio select.

// File: rtl/pix_load_pkg.sv
package pix_load_pkg;
    localparam int PIX_W     = 8;
    localparam int OVL_W     = 2;
    localparam int LANES_MAX = 5;

    typedef struct packed {
        logic [OVL_W-1:0] ovl;
        logic [PIX_W-1:0] pix;
    } lane_t;
endpackage

// File: rtl/pix_strobe_sync.sv
module pix_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic capture_o,
    output logic edge_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = strobe_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign capture_o = strobe_i & ~st_q.s1;
    assign edge_o    = st_q.s2 & ~st_q.s3;

    assert_edge_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> ($past(strobe_i, 2) && !$past(strobe_i, 3)));
endmodule

// File: rtl/pix_cadence_track.sv
module pix_cadence_track #(
    parameter int LANES_MAX = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic five_i,
    output logic locked_o
);
    localparam int CW = $clog2(LANES_MAX) + 1;
    localparam logic [CW-1:0] CNT_SAT    = '1;
    localparam logic [CW-1:0] LAST_LONG  = CW'(LANES_MAX - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(LANES_MAX - 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    hits;
        logic          five;
    } trk_t;

    trk_t st_d, st_q;
    logic [CW-1:0] last;
    logic          ratio_chg;

    always_comb begin
        last      = five_i ? LAST_LONG : LAST_SHORT;
        ratio_chg = (five_i != st_q.five);
        st_d      = st_q;
        st_d.five = five_i;
        if (edge_i)                 st_d.cnt = '0;
        else if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;

        if (ratio_chg) begin
            st_d.hits = 2'd0;
            if (!edge_i) st_d.cnt = CNT_SAT;
        end else if (edge_i) begin
            if (st_q.cnt == last)
                st_d.hits = (st_q.hits == 2'd2) ? 2'd2 : st_q.hits + 2'd1;
            else
                st_d.hits = 2'd0;
        end else if (st_q.cnt == last) begin
            st_d.hits = 2'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= CNT_SAT;
            st_q.hits <= 2'd0;
            st_q.five <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o = (st_q.hits == 2'd2);

    assert_ratio_unlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (five_i != st_q.five) |=> !locked_o);
    assert_mismatch_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && st_q.cnt != last) |=> !locked_o);
    assert_lock_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(edge_i));
endmodule

// File: rtl/pix_lane_serial.sv
module pix_lane_serial
    import pix_load_pkg::*;
#(
    parameter int LANES = LANES_MAX
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture_i,
    input  logic                  load_i,
    input  logic                  five_i,
    input  logic [LANES*$bits(lane_t)-1:0] word_i,
    output lane_t                 lane_o
);
    localparam int LW = $bits(lane_t);
    localparam int IW = $clog2(LANES);
    localparam logic [IW-1:0] LAST_LONG  = IW'(LANES - 1);
    localparam logic [IW-1:0] LAST_SHORT = IW'(LANES - 2);

    typedef struct packed {
        logic [LANES*LW-1:0] stage;
        lane_t [LANES-1:0]   bank;
        logic [IW-1:0]       idx;
    } ser_t;

    ser_t  st_d, st_q;
    lane_t [LANES-1:0] stage_lanes;
    logic [IW-1:0] last;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign stage_lanes[g] = lane_t'(st_q.stage[g*LW +: LW]);
    end

    always_comb begin
        last = five_i ? LAST_LONG : LAST_SHORT;
        st_d = st_q;
        if (capture_i) st_d.stage = word_i;
        if (load_i) begin
            st_d.bank = stage_lanes;
            st_d.idx  = '0;
        end else if (st_q.idx >= last) begin
            st_d.idx = '0;
        end else begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lane_o = st_q.bank[st_q.idx];

    assert_load_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.idx == '0));
endmodule

// File: rtl/pix_load_mux.sv
module pix_load_mux
    import pix_load_pkg::*;
#(
    parameter int LANES = LANES_MAX
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            strobe_i,
    input  logic                            five_i,
    input  logic [LANES*(PIX_W+OVL_W)-1:0]  word_i,
    output logic [PIX_W-1:0]                pix_o,
    output logic [OVL_W-1:0]                ovl_o,
    output logic                            locked_o
);
    logic  capture;
    logic  load;
    lane_t lane;

    pix_strobe_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (strobe_i),
        .capture_o (capture),
        .edge_o    (load)
    );

    pix_cadence_track #(.LANES_MAX(LANES)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (load),
        .five_i   (five_i),
        .locked_o (locked_o)
    );

    pix_lane_serial #(.LANES(LANES)) u_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .load_i    (load),
        .five_i    (five_i),
        .word_i    (word_i),
        .lane_o    (lane)
    );

    assign pix_o = lane.pix;
    assign ovl_o = lane.ovl;
endmodule

// File: tb/pix_load_mux_test.sv
module pix_load_mux_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_i = 1'b0;
    logic        five_i = 1'b0;
    logic [49:0] word_i = '0;
    logic [7:0]  pix_o;
    logic [1:0]  ovl_o;
    logic        locked_o;

    pix_load_mux uut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .five_i(five_i),
        .word_i(word_i), .pix_o(pix_o), .ovl_o(ovl_o), .locked_o(locked_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        int         cyc;
        logic [7:0] pix;
        logic [1:0] ovl;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares each expected lane in its stamped cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc < cyc) begin
            n_run++; n_fail++;
            $display("FAIL %s lane missed at cycle %0d (actual none, expected pix %0h)",
                     q[0].tag, q[0].cyc, q[0].pix);
            void'(q.pop_front());
        end
        if (q.size() > 0 && q[0].cyc == cyc) begin
            n_run++;
            if (pix_o !== q[0].pix || ovl_o !== q[0].ovl) begin
                n_fail++;
                $display("FAIL %s cycle %0d actual %0h/%0h expected %0h/%0h",
                         q[0].tag, cyc, pix_o, ovl_o, q[0].pix, q[0].ovl);
            end
            void'(q.pop_front());
        end
    end

    function automatic logic [49:0] mk_word(input int k);
        logic [49:0] w;
        for (int i = 0; i < 5; i++) begin
            w[i*10 +: 8]     = 8'((k * 37 + i * 11 + 5) % 256);
            w[i*10 + 8 +: 2] = 2'((k + i) % 4);
        end
        return w;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // driver: called at a negedge; pushes the lanes expected from this strobe
    task automatic send_word(input logic [49:0] w, input int period);
        int    n = five_i ? 5 : 4;
        int    c = cyc;
        string tag = (period > n) ? "R4 wrap" : (period < n) ? "R9 early" : "R1 R2 R3";
        word_i   = w;
        strobe_i = 1'b1;
        for (int i = 0; i < period; i++) begin
            exp_t e;
            e.cyc = c + 3 + i;
            e.pix = w[(i % n)*10 +: 8];
            e.ovl = w[(i % n)*10 + 8 +: 2];
            e.tag = tag;
            q.push_back(e);
        end
        repeat (2) @(negedge clk);
        strobe_i = 1'b0;
        repeat (period - 2) @(negedge clk);
    endtask

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check_bit("R8 locked in reset", locked_o, 1'b0);
        check_bit("R8 pix zero in reset", pix_o == 8'd0, 1'b1);
        check_bit("R8 ovl zero in reset", ovl_o == 2'd0, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // 4:1 train: R5 needs two on-time edges after the first
        send_word(mk_word(1), 4);
        send_word(mk_word(2), 4);
        check_bit("R5 not locked after one on-time edge", locked_o, 1'b0);
        send_word(mk_word(3), 4);
        check_bit("R5 locked after two on-time edges", locked_o, 1'b1);
        send_word(mk_word(4), 4);
        send_word(mk_word(5), 6);      // next edge late
        send_word(mk_word(6), 4);
        check_bit("R6 late edge clears lock", locked_o, 1'b0);
        send_word(mk_word(7), 4);
        send_word(mk_word(8), 4);
        check_bit("R6 relock after two on-time edges", locked_o, 1'b1);
        send_word(mk_word(9), 3);      // early edge truncates rotation, R9
        send_word(mk_word(10), 4);
        check_bit("R6 early edge clears lock", locked_o, 1'b0);
        send_word(mk_word(11), 4);
        send_word(mk_word(12), 4);
        check_bit("R5 relocked", locked_o, 1'b1);

        // R7 ratio change
        five_i = 1'b1;
        @(negedge clk);
        check_bit("R7 ratio change clears lock", locked_o, 1'b0);
        repeat (6) @(negedge clk);

        // 5:1 train
        for (int k = 20; k < 25; k++) send_word(mk_word(k), 5);
        check_bit("R5 locked in 5:1", locked_o, 1'b1);
        send_word(mk_word(25), 12);    // long gap: lanes wrap (R4), edge missed (R6)
        check_bit("R6 missing edge clears lock", locked_o, 1'b0);

        five_i = 1'b0;
        repeat (3) @(negedge clk);
        send_word(mk_word(30), 4);
        send_word(mk_word(31), 10);    // R4 wrap in 4:1
        repeat (4) @(negedge clk);

        n_run++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R3 queue not drained (actual %0d, expected 0)", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule